// File: doc/BRIEF.md
# Link Configuration Fallback Selector

After a failed training attempt on a serial display link, the controller must choose a slower link setting to try next. This block makes that choice in hardware. It holds a fixed list of nine combinations of link rate and lane count, ordered from fastest to slowest. The list is lane-count-major: all three rates are tried at four lanes before any two-lane setting is tried, and all two-lane settings are tried before any one-lane setting.

A start pulse captures the current rate and lane count together with the largest rate and lane count the sink supports. The block then walks the list one entry per clock. It first finds the entry equal to the current setting. From the entry after that one, it looks for the first entry that the sink limits allow. The answer is shown with a one-cycle done strobe. A not-found flag is raised when the current setting is not in the list, when it is already the last entry, or when no later entry fits the limits. Whether the new setting has enough bandwidth for the video mode is decided elsewhere.

Top module: `link_fallback_sel`

## Requirements
- R1: After reset, done_o and none_o are low, and next_rate_o and next_lanes_o are zero.
- R2: The list, by index 0 to 8, is: rate 0x14 with 4 lanes, 0x0A×4, 0x06×4, 0x14×2, 0x0A×2, 0x06×2, 0x14×1, 0x0A×1, 0x06×1. Rate code 0x14 means 5.4G, 0x0A means 2.7G and 0x06 means 1.62G. Lane counts are plain binary.
- R3: If the captured current rate and lane count match no list entry, the result is not-found.
- R4: Otherwise the result is the first entry after the matching entry whose rate code is at most the maximum rate code and whose lane count is at most the maximum lane count.
- R5: If the matching entry is index 8, the result is not-found.
- R6: If no entry after the matching one meets both limits, the result is not-found.
- R7: done_o is high for exactly one cycle per search. The results stay unchanged until the next accepted start. A not-found result shows none_o high with next_rate_o and next_lanes_o at zero.
- R8: The search examines one entry per clock. If start_i is sampled on edge 0, then done_o is high after edge f+1 for a result at index f. For every not-found case, done_o is high after edge 9.
- R9: The inputs are captured on the edge that accepts start_i. A start_i pulse during a search is ignored, and later changes to the inputs do not affect that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when idle |
| cur_rate_i | input | 8 | Current rate code |
| cur_lanes_i | input | 3 | Current lane count |
| max_rate_i | input | 8 | Highest rate code the sink supports |
| max_lanes_i | input | 3 | Highest lane count the sink supports |
| next_rate_o | output | 8 | Selected rate code, or zero when not found |
| next_lanes_o | output | 3 | Selected lane count, or zero when not found |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| none_o | output | 1 | No lower configuration is available |

## Verification
A wrong walk index or a wrong phase shows at the ports in one of two ways: a wrong entry is returned, or done_o arrives on the wrong edge. Because latency equals the index of the result plus one, an error appears within nine cycles of start. Corrupted captured limits give a result that breaks the maximum rate or lane count. A control state that never leaves the search is seen as a missing done strobe. An accepted start during a search is seen as a result and a latency that belong to the second request instead of the first.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   localparam int unsigned LFS_ENTRIES = 9;
   localparam int unsigned LFS_RATE_HI = 'h14;
   localparam int unsigned LFS_RATE_MD = 'h0A;
   localparam int unsigned LFS_RATE_LO = 'h06;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FIND = 2'd1,
      ST_SCAN = 2'd2
   } lfs_state_e;

   // rate of list entry i: three rates descending within each lane group
   function automatic int unsigned lfs_rate_at(input int unsigned i);
      case (i % 3)
         0:       return LFS_RATE_HI;
         1:       return LFS_RATE_MD;
         default: return LFS_RATE_LO;
      endcase
   endfunction

   // lane count of list entry i: 4, 2, 1 per group of three
   function automatic int unsigned lfs_lanes_at(input int unsigned i);
      return 4 >> (i / 3);
   endfunction

endpackage

// File: rtl/link_fallback_rom.sv
module link_fallback_rom
   import lfs_pkg::*;
#(
   parameter int unsigned RATE_W  = 8,
   parameter int unsigned LANE_W  = 3,
   parameter int unsigned ENTRIES = LFS_ENTRIES,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic [IDX_W-1:0]  idx_i,
   output logic [RATE_W-1:0] rate_o,
   output logic [LANE_W-1:0] lanes_o
);

   logic [RATE_W-1:0] tbl_rate  [ENTRIES];
   logic [LANE_W-1:0] tbl_lanes [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      assign tbl_rate[g]  = RATE_W'(lfs_rate_at(g));
      assign tbl_lanes[g] = LANE_W'(lfs_lanes_at(g));
   end

   always_comb begin
      rate_o  = '0;
      lanes_o = '0;
      for (int unsigned k = 0; k < ENTRIES; k++) begin
         if (idx_i == IDX_W'(k)) begin
            rate_o  = tbl_rate[k];
            lanes_o = tbl_lanes[k];
         end
      end
   end

endmodule

// File: rtl/link_fallback_cmp.sv
module link_fallback_cmp #(
   parameter int unsigned RATE_W = 8,
   parameter int unsigned LANE_W = 3
) (
   input  logic [RATE_W-1:0] ent_rate_i,
   input  logic [LANE_W-1:0] ent_lanes_i,
   input  logic [RATE_W-1:0] cur_rate_i,
   input  logic [LANE_W-1:0] cur_lanes_i,
   input  logic [RATE_W-1:0] max_rate_i,
   input  logic [LANE_W-1:0] max_lanes_i,
   output logic              is_cur_o,
   output logic              fits_o
);

   assign is_cur_o = (ent_rate_i == cur_rate_i) && (ent_lanes_i == cur_lanes_i);
   assign fits_o   = (ent_rate_i <= max_rate_i) && (ent_lanes_i <= max_lanes_i);

endmodule

// File: rtl/link_fallback_seq.sv
module link_fallback_seq
   import lfs_pkg::*;
#(
   parameter int unsigned RATE_W  = 8,
   parameter int unsigned LANE_W  = 3,
   parameter int unsigned ENTRIES = LFS_ENTRIES,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] cur_rate_i,
   input  logic [LANE_W-1:0] cur_lanes_i,
   input  logic [RATE_W-1:0] max_rate_i,
   input  logic [LANE_W-1:0] max_lanes_i,
   input  logic              is_cur_i,
   input  logic              fits_i,
   input  logic [RATE_W-1:0] ent_rate_i,
   input  logic [LANE_W-1:0] ent_lanes_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [RATE_W-1:0] cur_rate_q,
   output logic [LANE_W-1:0] cur_lanes_q,
   output logic [RATE_W-1:0] max_rate_q,
   output logic [LANE_W-1:0] max_lanes_q,
   output logic [RATE_W-1:0] next_rate_o,
   output logic [LANE_W-1:0] next_lanes_o,
   output logic              done_o,
   output logic              none_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   lfs_state_e state_q;
   logic       at_last;

   assign at_last = (idx_o == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         idx_o        <= '0;
         cur_rate_q   <= '0;
         cur_lanes_q  <= '0;
         max_rate_q   <= '0;
         max_lanes_q  <= '0;
         next_rate_o  <= '0;
         next_lanes_o <= '0;
         done_o       <= 1'b0;
         none_o       <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cur_rate_q  <= cur_rate_i;
                  cur_lanes_q <= cur_lanes_i;
                  max_rate_q  <= max_rate_i;
                  max_lanes_q <= max_lanes_i;
                  idx_o       <= '0;
                  state_q     <= ST_FIND;
               end
            end
            ST_FIND: begin
               if (is_cur_i && !at_last) begin
                  idx_o   <= idx_o + 1'b1;
                  state_q <= ST_SCAN;
               end else if (at_last) begin
                  done_o       <= 1'b1;
                  none_o       <= 1'b1;
                  next_rate_o  <= '0;
                  next_lanes_o <= '0;
                  state_q      <= ST_IDLE;
               end else begin
                  idx_o <= idx_o + 1'b1;
               end
            end
            ST_SCAN: begin
               if (fits_i) begin
                  done_o       <= 1'b1;
                  none_o       <= 1'b0;
                  next_rate_o  <= ent_rate_i;
                  next_lanes_o <= ent_lanes_i;
                  state_q      <= ST_IDLE;
               end else if (at_last) begin
                  done_o       <= 1'b1;
                  none_o       <= 1'b1;
                  next_rate_o  <= '0;
                  next_lanes_o <= '0;
                  state_q      <= ST_IDLE;
               end else begin
                  idx_o <= idx_o + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R7: strobe lasts a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: results held while idle and no new start
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !start_i) |=>
         ($stable(next_rate_o) && $stable(next_lanes_o) && $stable(none_o)));

   // R7: not-found clears the configuration outputs
   p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && none_o) |-> (next_rate_o == '0 && next_lanes_o == '0));

   // R4: a returned entry obeys the captured limits
   p_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !none_o) |->
         (next_rate_o <= max_rate_q && next_lanes_o <= max_lanes_q && next_rate_o != '0));

   // R2: a returned lane count is 1, 2 or 4
   p_lane_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !none_o) |-> ($countones(next_lanes_o) == 1));

   // R9: captured inputs do not move during a search
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=>
         ($stable(max_rate_q) && $stable(max_lanes_q) &&
          $stable(cur_rate_q) && $stable(cur_lanes_q)));

endmodule

// File: rtl/link_fallback_sel.sv
module link_fallback_sel
   import lfs_pkg::*;
#(
   parameter int unsigned RATE_W = 8,
   parameter int unsigned LANE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [RATE_W-1:0] cur_rate_i,
   input  logic [LANE_W-1:0] cur_lanes_i,
   input  logic [RATE_W-1:0] max_rate_i,
   input  logic [LANE_W-1:0] max_lanes_i,
   output logic [RATE_W-1:0] next_rate_o,
   output logic [LANE_W-1:0] next_lanes_o,
   output logic              done_o,
   output logic              none_o
);

   localparam int unsigned ENTRIES = LFS_ENTRIES;
   localparam int unsigned IDX_W   = $clog2(ENTRIES);

   if (RATE_W < 5) begin : g_bad_rate_w
      $error("RATE_W too narrow for the rate codes");
   end
   if (LANE_W < 3) begin : g_bad_lane_w
      $error("LANE_W too narrow for a lane count of four");
   end

   logic [IDX_W-1:0]  idx;
   logic [RATE_W-1:0] ent_rate, cur_rate_q, max_rate_q;
   logic [LANE_W-1:0] ent_lanes, cur_lanes_q, max_lanes_q;
   logic              is_cur, fits;

   link_fallback_rom #(
      .RATE_W(RATE_W), .LANE_W(LANE_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) rom_i (
      .idx_i(idx), .rate_o(ent_rate), .lanes_o(ent_lanes)
   );

   link_fallback_cmp #(
      .RATE_W(RATE_W), .LANE_W(LANE_W)
   ) cmp_i (
      .ent_rate_i(ent_rate), .ent_lanes_i(ent_lanes),
      .cur_rate_i(cur_rate_q), .cur_lanes_i(cur_lanes_q),
      .max_rate_i(max_rate_q), .max_lanes_i(max_lanes_q),
      .is_cur_o(is_cur), .fits_o(fits)
   );

   link_fallback_seq #(
      .RATE_W(RATE_W), .LANE_W(LANE_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cur_rate_i(cur_rate_i), .cur_lanes_i(cur_lanes_i),
      .max_rate_i(max_rate_i), .max_lanes_i(max_lanes_i),
      .is_cur_i(is_cur), .fits_i(fits),
      .ent_rate_i(ent_rate), .ent_lanes_i(ent_lanes),
      .idx_o(idx),
      .cur_rate_q(cur_rate_q), .cur_lanes_q(cur_lanes_q),
      .max_rate_q(max_rate_q), .max_lanes_q(max_lanes_q),
      .next_rate_o(next_rate_o), .next_lanes_o(next_lanes_o),
      .done_o(done_o), .none_o(none_o)
   );

endmodule

// File: tb/link_fallback_sel_tb_top.sv
module link_fallback_sel_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] cur_rate_i = '0, max_rate_i = '0;
   logic [2:0] cur_lanes_i = '0, max_lanes_i = '0;
   logic [7:0] next_rate_o;
   logic [2:0] next_lanes_o;
   logic       done_o, none_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   link_fallback_sel dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cur_rate_i(cur_rate_i), .cur_lanes_i(cur_lanes_i),
      .max_rate_i(max_rate_i), .max_lanes_i(max_lanes_i),
      .next_rate_o(next_rate_o), .next_lanes_o(next_lanes_o),
      .done_o(done_o), .none_o(none_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // R2 list as written in the requirement
   function automatic int ref_rate(input int i);
      int r[9] = '{'h14, 'h0A, 'h06, 'h14, 'h0A, 'h06, 'h14, 'h0A, 'h06};
      return r[i];
   endfunction
   function automatic int ref_lanes(input int i);
      int l[9] = '{4, 4, 4, 2, 2, 2, 1, 1, 1};
      return l[i];
   endfunction

   // run one search; optionally inject a second start two cycles in
   task automatic run(input string req, input int cr, input int cl, input int mr, input int ml,
                      input bit exp_none, input int exp_idx, input bit inject);
      int lat;
      int exp_lat;
      @(negedge clk);
      cur_rate_i = 8'(cr); cur_lanes_i = 3'(cl);
      max_rate_i = 8'(mr); max_lanes_i = 3'(ml);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      for (int k = 0; k < 20; k++) begin
         if (inject && k == 2) begin
            @(negedge clk);
            start_i = 1'b1;
            cur_rate_i = 8'h14; cur_lanes_i = 3'd4;
            max_rate_i = 8'h14; max_lanes_i = 3'd4;
         end
         @(posedge clk);
         lat++;
         #1;
         if (inject && k == 2) begin
            @(negedge clk);
            start_i = 1'b0;
            #0;
         end
         if (done_o) break;
      end
      exp_lat = exp_none ? 9 : exp_idx + 1;
      check(req, "latency R8", lat, exp_lat);
      check(req, "none", int'(none_o), int'(exp_none));
      check(req, "rate", int'(next_rate_o), exp_none ? 0 : ref_rate(exp_idx));
      check(req, "lanes", int'(next_lanes_o), exp_none ? 0 : ref_lanes(exp_idx));
      @(posedge clk); #1;
      check("R7", "done after one cycle", int'(done_o), 0);
   endtask

   task automatic t_hold();
      int r, l, n;
      r = next_rate_o; l = next_lanes_o; n = none_o;
      @(negedge clk);
      cur_rate_i = 8'h06; cur_lanes_i = 3'd1; max_rate_i = 8'h00; max_lanes_i = 3'd0;
      repeat (5) @(posedge clk);
      #1;
      check("R7", "held rate", int'(next_rate_o), r);
      check("R7", "held lanes", int'(next_lanes_o), l);
      check("R7", "held none", int'(none_o), n);
      check("R7", "no stray done", int'(done_o), 0);
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset done", int'(done_o), 0);
      check("R1", "reset none", int'(none_o), 0);
      check("R1", "reset rate", int'(next_rate_o), 0);
      check("R1", "reset lanes", int'(next_lanes_o), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      // R4 / R2: step through the lane-count-major order
      run("R4", 'h14, 4, 'h14, 4, 0, 1, 0);
      t_hold();
      run("R4", 'h0A, 4, 'h14, 4, 0, 2, 0);
      run("R2", 'h06, 4, 'h14, 4, 0, 3, 0);
      run("R4", 'h14, 4, 'h06, 4, 0, 2, 0);
      run("R4", 'h14, 4, 'h0A, 2, 0, 4, 0);
      run("R4", 'h14, 2, 'h06, 1, 0, 8, 0);
      run("R2", 'h0A, 1, 'h14, 4, 0, 8, 0);
      // R5: already lowest
      run("R5", 'h06, 1, 'h14, 4, 1, 0, 0);
      t_hold();
      // R3: current not in list
      run("R3", 'h0A, 3, 'h14, 4, 1, 0, 0);
      run("R3", 'h10, 4, 'h14, 4, 1, 0, 0);
      // R6: nothing later qualifies
      run("R6", 'h14, 1, 'h05, 4, 1, 0, 0);
      run("R6", 'h14, 4, 'h14, 0, 1, 0, 0);
      // R9: start during search ignored
      run("R9", 'h14, 2, 'h06, 1, 0, 8, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule